// File: doc/BRIEF.md
# Rollback-Capable Delayed-Write Register File

This block is a register file whose writes do not go straight into the storage array. Each write first enters a short shift queue, and it reaches the array only after it has travelled the full length of that queue. Every clock cycle pushes one queue slot. A cycle with no write pushes an empty bubble, so the queue position of an entry always equals its age in cycles.

Because of this, the last p cycles of writes can be cancelled in a single cycle by clearing the valid bits of the p newest slots. A checker that reports an error a few cycles late can therefore undo whatever the register file absorbed in the meantime.

Two read ports search the queue associatively. A read returns the newest queued value for its address. When no valid slot matches, it returns the value held in the array.

Top module: `rbk_regfile`

## Requirements
- R1: After reset every queue slot is invalid, every array word is zero, both read ports return zero and `rb_err` is low.
- R2: A write accepted at a clock edge is seen by reads from the following cycle. A read of the same address in the cycle the write is presented returns the value stored before it.
- R3: When several valid queue slots hold the read address, the read returns the data of the slot pushed most recently.
- R4: When no valid queue slot holds the read address, the read returns the array word at that address.
- R5: A write retires into the array at the DEPTH-th clock edge after it was accepted. After that edge no rollback can cancel it.
- R6: A rollback with a count p in 1..DEPTH cancels every write accepted in the last p cycles. Cycles without writes count toward p. The effect is visible from the next cycle.
- R7: In a cycle that carries a valid rollback, the write inputs are ignored and no new entry enters the queue.
- R8: A rollback request with count 0, or with a count above DEPTH, cancels nothing. The write of that cycle is accepted normally, and `rb_err` is high for exactly the following cycle.
- R9: The two read ports look up different addresses independently in the same cycle.
- R10: In a rollback cycle the oldest slot still retires into the array if p is below DEPTH. It is discarded if p equals DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write request for this cycle |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| rd0_addr | input | ADDR_W | Read port 0 address |
| rd0_data | output | DATA_W | Read port 0 data (combinational) |
| rd1_addr | input | ADDR_W | Read port 1 address |
| rd1_data | output | DATA_W | Read port 1 data (combinational) |
| rb_req | input | 1 | Rollback request |
| rb_count | input | CNT_W | Number of cycles to roll back |
| rb_err | output | 1 | One-cycle flag for a rejected rollback count |

## Verification
Two pairs of functions can fall in the same cycle: a rollback and the retirement of the oldest slot, and a rollback and a presented write.

The bench provokes the first pair by writing a word and then idling exactly DEPTH-1 cycles before rolling back. A count of DEPTH must erase that word, while a count of DEPTH-1 must let it land in the array.

For the second pair, it presents a write on the rollback cycle and reads that address afterwards to confirm the old value. A behavioural model of ages and retirements judges every read of both ports across full address sweeps.

// File: rtl/rbk_pkg.sv
package rbk_pkg;
   // what a single cycle does to the queue
   typedef enum logic [1:0] {
      OP_IDLE  = 2'd0,
      OP_WRITE = 2'd1,
      OP_ROLL  = 2'd2
   } rbk_op_e;
endpackage

// File: rtl/rbk_array.sv
module rbk_array #(
   parameter int ADDR_W = 7,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd0_addr,
   output logic [DATA_W-1:0] rd0_data,
   input  logic [ADDR_W-1:0] rd1_addr,
   output logic [DATA_W-1:0] rd1_data
);
   localparam int WORDS = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [WORDS];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int w = 0; w < WORDS; w++) mem[w] <= '0;
      end else if (wr_en) begin
         mem[wr_addr] <= wr_data;
      end
   end

   assign rd0_data = mem[rd0_addr];
   assign rd1_data = mem[rd1_addr];
endmodule

// File: rtl/rbk_queue.sv
module rbk_queue #(
   parameter int ADDR_W = 7,
   parameter int DATA_W = 32,
   parameter int DEPTH  = 4,
   parameter int CNT_W  = 4
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          push_vld,
   input  logic [ADDR_W-1:0]             push_addr,
   input  logic [DATA_W-1:0]             push_data,
   input  logic                          roll,
   input  logic [CNT_W-1:0]              roll_cnt,
   output logic [DEPTH-1:0]              q_vld,
   output logic [DEPTH-1:0][ADDR_W-1:0]  q_addr,
   output logic [DEPTH-1:0][DATA_W-1:0]  q_data,
   output logic                          ret_en,
   output logic [ADDR_W-1:0]             ret_addr,
   output logic [DATA_W-1:0]             ret_data
);
   // slot 0 is the newest, slot DEPTH-1 the oldest
   logic [DEPTH-1:0] kill;

   for (genvar i = 0; i < DEPTH; i++) begin : g_kill
      assign kill[i] = roll && (roll_cnt > CNT_W'(i));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q_vld <= '0;
      end else begin
         q_vld[0] <= push_vld;
         for (int i = 1; i < DEPTH; i++) q_vld[i] <= q_vld[i-1] & ~kill[i-1];
      end
   end

   always_ff @(posedge clk) begin
      q_addr[0] <= push_addr;
      q_data[0] <= push_data;
      for (int i = 1; i < DEPTH; i++) begin
         q_addr[i] <= q_addr[i-1];
         q_data[i] <= q_data[i-1];
      end
   end

   assign ret_en   = q_vld[DEPTH-1] & ~kill[DEPTH-1];
   assign ret_addr = q_addr[DEPTH-1];
   assign ret_data = q_data[DEPTH-1];
endmodule

// File: rtl/rbk_match.sv
module rbk_match #(
   parameter int ADDR_W = 7,
   parameter int DATA_W = 32,
   parameter int DEPTH  = 4
) (
   input  logic [DEPTH-1:0]             q_vld,
   input  logic [DEPTH-1:0][ADDR_W-1:0] q_addr,
   input  logic [DEPTH-1:0][DATA_W-1:0] q_data,
   input  logic [ADDR_W-1:0]            rd_addr,
   input  logic [DATA_W-1:0]            arr_data,
   output logic [DATA_W-1:0]            rd_data
);
   // walk from oldest to newest so the newest match wins
   always_comb begin
      rd_data = arr_data;
      for (int i = DEPTH - 1; i >= 0; i--) begin
         if (q_vld[i] && (q_addr[i] == rd_addr)) rd_data = q_data[i];
      end
   end
endmodule

// File: rtl/rbk_regfile.sv
module rbk_regfile #(
   parameter int ADDR_W = 7,
   parameter int DATA_W = 32,
   parameter int DEPTH  = 4,
   parameter int CNT_W  = $clog2(DEPTH + 1) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd0_addr,
   output logic [DATA_W-1:0] rd0_data,
   input  logic [ADDR_W-1:0] rd1_addr,
   output logic [DATA_W-1:0] rd1_data,
   input  logic              rb_req,
   input  logic [CNT_W-1:0]  rb_count,
   output logic              rb_err
);
   import rbk_pkg::*;

   localparam int NPORT = 2;

   if (DEPTH < 1) begin : g_bad_depth
      $error("rbk_regfile: DEPTH must be at least 1");
   end
   if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
      $error("rbk_regfile: ADDR_W and DATA_W must be positive");
   end
   if ((1 << CNT_W) <= DEPTH) begin : g_bad_cnt
      $error("rbk_regfile: CNT_W too narrow to express DEPTH");
   end

   logic     cnt_bad;
   rbk_op_e  op;
   logic     push_vld;
   logic     roll;

   assign cnt_bad = (rb_count == '0) || (rb_count > CNT_W'(DEPTH));

   always_comb begin
      if (rb_req && !cnt_bad) op = OP_ROLL;
      else if (wr_en)         op = OP_WRITE;
      else                    op = OP_IDLE;
   end

   assign roll     = (op == OP_ROLL);
   assign push_vld = (op == OP_WRITE);

   always_ff @(posedge clk) begin
      if (!rst_n) rb_err <= 1'b0;
      else        rb_err <= rb_req && cnt_bad;
   end

   logic [DEPTH-1:0]             q_vld;
   logic [DEPTH-1:0][ADDR_W-1:0] q_addr;
   logic [DEPTH-1:0][DATA_W-1:0] q_data;
   logic                         ret_en;
   logic [ADDR_W-1:0]            ret_addr;
   logic [DATA_W-1:0]            ret_data;

   rbk_queue #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)
   ) queue_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .push_vld (push_vld),
      .push_addr(wr_addr),
      .push_data(wr_data),
      .roll     (roll),
      .roll_cnt (rb_count),
      .q_vld    (q_vld),
      .q_addr   (q_addr),
      .q_data   (q_data),
      .ret_en   (ret_en),
      .ret_addr (ret_addr),
      .ret_data (ret_data)
   );

   logic [NPORT-1:0][ADDR_W-1:0] rd_addr_v;
   logic [NPORT-1:0][DATA_W-1:0] arr_rd_v;
   logic [NPORT-1:0][DATA_W-1:0] rd_data_v;

   assign rd_addr_v[0] = rd0_addr;
   assign rd_addr_v[1] = rd1_addr;
   assign rd0_data     = rd_data_v[0];
   assign rd1_data     = rd_data_v[1];

   rbk_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) array_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (ret_en),
      .wr_addr (ret_addr),
      .wr_data (ret_data),
      .rd0_addr(rd_addr_v[0]),
      .rd0_data(arr_rd_v[0]),
      .rd1_addr(rd_addr_v[1]),
      .rd1_data(arr_rd_v[1])
   );

   for (genvar p = 0; p < NPORT; p++) begin : g_port
      rbk_match #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) match_i (
         .q_vld   (q_vld),
         .q_addr  (q_addr),
         .q_data  (q_data),
         .rd_addr (rd_addr_v[p]),
         .arr_data(arr_rd_v[p]),
         .rd_data (rd_data_v[p])
      );
   end
endmodule

// File: rtl/rbk_regfile_chk.sv
module rbk_regfile_chk #(
   parameter int DEPTH = 4,
   parameter int CNT_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic             rb_req,
   input logic [CNT_W-1:0] rb_count,
   input logic             rb_err,
   input logic [DEPTH-1:0] q_vld,
   input logic             ret_en
);
   logic bad_cnt;
   logic good_roll;
   assign bad_cnt   = (rb_count == '0) || (rb_count > CNT_W'(DEPTH));
   assign good_roll = rb_req && !bad_cnt;

   // R8: a rejected count raises the flag on the next cycle
   p_err_raise_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rb_req && bad_cnt) |=> rb_err);

   // R8: the flag never rises without a rejected count before it
   p_err_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rb_err && !$past(!rst_n)) |-> $past(rb_req && bad_cnt));

   // R2: an accepted write occupies the newest slot next cycle
   p_push_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !good_roll) |=> q_vld[0]);

   // R7: a rollback cycle pushes an empty slot even with a write presented
   p_roll_bubble_r7: assert property (@(posedge clk) disable iff (!rst_n)
      good_roll |=> !q_vld[0]);

   // R10: a full-depth rollback lets nothing retire
   p_full_roll_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (good_roll && rb_count == CNT_W'(DEPTH)) |-> !ret_en);

   // R1: nothing retires in the first cycle after reset
   p_reset_empty_r1: assert property (@(posedge clk)
      $past(!rst_n) && rst_n |-> !ret_en);
endmodule

bind rbk_regfile rbk_regfile_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) chk_i (
   .clk     (clk),
   .rst_n   (rst_n),
   .wr_en   (wr_en),
   .rb_req  (rb_req),
   .rb_count(rb_count),
   .rb_err  (rb_err),
   .q_vld   (q_vld),
   .ret_en  (ret_en)
);

// File: tb/rbk_regfile_tb.sv
`timescale 1ns/1ps
module rbk_regfile_tb_top;
   localparam int AW = 7;
   localparam int DW = 32;
   localparam int DEPTH = 4;
   localparam int CW = 4;
   localparam int WORDS = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic [AW-1:0] rd0_addr = '0;
   logic [AW-1:0] rd1_addr = '0;
   logic [DW-1:0] rd0_data, rd1_data;
   logic          rb_req = 1'b0;
   logic [CW-1:0] rb_count = '0;
   logic          rb_err;

   always #2.5 clk = ~clk;

   rbk_regfile #(.ADDR_W(AW), .DATA_W(DW), .DEPTH(DEPTH), .CNT_W(CW)) dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd0_addr(rd0_addr), .rd0_data(rd0_data),
      .rd1_addr(rd1_addr), .rd1_data(rd1_data), .rb_req(rb_req),
      .rb_count(rb_count), .rb_err(rb_err)
   );

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // behavioural model: slot 0 newest
   logic [DW-1:0] mm [WORDS];
   logic          mq_v [DEPTH];
   logic [AW-1:0] mq_a [DEPTH];
   logic [DW-1:0] mq_d [DEPTH];
   logic          err_exp = 1'b0;

   function automatic logic [DW-1:0] mread(input logic [AW-1:0] a);
      logic [DW-1:0] r;
      r = mm[a];
      for (int i = DEPTH - 1; i >= 0; i--) if (mq_v[i] && mq_a[i] == a) r = mq_d[i];
      return r;
   endfunction

   task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic model_step(input logic we, input logic [AW-1:0] wa, input logic [DW-1:0] wd,
                             input logic rb, input logic [CW-1:0] rc);
      logic keep;
      keep = we;
      err_exp = rb && (rc == 0 || rc > DEPTH);
      if (rb && !err_exp) begin
         for (int i = 0; i < DEPTH; i++) if (i < rc) mq_v[i] = 1'b0;
         keep = 1'b0;
      end
      if (mq_v[DEPTH-1]) mm[mq_a[DEPTH-1]] = mq_d[DEPTH-1];
      for (int i = DEPTH - 1; i >= 1; i--) begin
         mq_v[i] = mq_v[i-1]; mq_a[i] = mq_a[i-1]; mq_d[i] = mq_d[i-1];
      end
      mq_v[0] = keep; mq_a[0] = wa; mq_d[0] = wd;
   endtask

   // one cycle; starts and ends at a falling edge
   task automatic step(input logic we, input logic [AW-1:0] wa, input logic [DW-1:0] wd,
                       input logic rb, input logic [CW-1:0] rc,
                       input logic [AW-1:0] ra1, input string tag);
      wr_en = we; wr_addr = wa; wr_data = wd; rb_req = rb; rb_count = rc;
      rd0_addr = wa; rd1_addr = ra1;
      #1;
      chk({"R2 same-cycle read ", tag}, rd0_data, mread(wa));
      chk({"R9 port1 read ", tag}, rd1_data, mread(ra1));
      @(posedge clk);
      model_step(we, wa, wd, rb, rc);
      @(negedge clk);
      wr_en = 1'b0; rb_req = 1'b0;
      chk("R8 rb_err", {31'd0, rb_err}, {31'd0, err_exp});
   endtask

   task automatic probe(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string tag);
      rd0_addr = a; rd1_addr = a;
      #1;
      chk({tag, " port0"}, rd0_data, exp);
      chk({tag, " port1"}, rd1_data, exp);
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) step(1'b0, '0, '0, 1'b0, '0, '0, "idle");
   endtask

   function automatic logic [DW-1:0] pat(input int a, input int s);
      return (32'h5A000000 + s * 32'h00010000) ^ (a * 32'h01010101);
   endfunction

   initial begin
      for (int a = 0; a < WORDS; a++) mm[a] = '0;
      for (int i = 0; i < DEPTH; i++) begin mq_v[i] = 1'b0; mq_a[i] = '0; mq_d[i] = '0; end
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      for (int a = 0; a < WORDS; a += 17) probe(AW'(a), '0, "R1 reset read");
      chk("R1 rb_err after reset", {31'd0, rb_err}, 32'd0);

      // sweep: write every address, read the previous one on port 1 (R4, R9)
      for (int a = 0; a < WORDS; a++)
         step(1'b1, AW'(a), pat(a, 0), 1'b0, '0, AW'(a - 1), "R4 sweep");
      idle(DEPTH);
      for (int a = 0; a < WORDS; a++) probe(AW'(a), pat(a, 0), "R4 array read");

      // R2: visible next cycle
      step(1'b1, 7'd3, 32'h00000333, 1'b0, '0, 7'd3, "R2");
      probe(7'd3, 32'h00000333, "R2 next-cycle read");

      // R3: newest of several matches
      step(1'b1, 7'd5, 32'h1, 1'b0, '0, 7'd5, "R3");
      step(1'b1, 7'd5, 32'h2, 1'b0, '0, 7'd5, "R3");
      step(1'b1, 7'd5, 32'h3, 1'b0, '0, 7'd5, "R3");
      probe(7'd5, 32'h3, "R3 newest match");

      // R6: cancel last writes, bubbles count toward p
      idle(DEPTH);
      step(1'b1, 7'd9, 32'hDEAD0009, 1'b0, '0, 7'd9, "R6");
      step(1'b1, 7'd9, 32'hBEEF0009, 1'b0, '0, 7'd9, "R6");
      step(1'b0, '0, '0, 1'b1, 4'd1, 7'd9, "R6 roll1");
      probe(7'd9, 32'hDEAD0009, "R6 rollback 1");
      step(1'b1, 7'd10, 32'h0A0A0A0A, 1'b0, '0, 7'd10, "R6");
      idle(2);
      step(1'b0, '0, '0, 1'b1, 4'd2, 7'd10, "R6 roll2");
      probe(7'd10, 32'h0A0A0A0A, "R6 bubbles only cancelled");
      step(1'b0, '0, '0, 1'b1, 4'd4, 7'd10, "R6 roll4");
      probe(7'd10, pat(10, 0), "R6 write cancelled");

      // R7: write presented with a rollback is dropped
      idle(DEPTH);
      step(1'b1, 7'd30, 32'h77777777, 1'b1, 4'd1, 7'd30, "R7");
      probe(7'd30, pat(30, 0), "R7 write ignored");

      // R8: rejected counts
      step(1'b1, 7'd31, 32'h31313131, 1'b0, '0, 7'd31, "R8");
      step(1'b1, 7'd31, 32'h31310000, 1'b1, 4'd0, 7'd31, "R8 count0");
      probe(7'd31, 32'h31310000, "R8 count0 write kept");
      step(1'b0, '0, '0, 1'b1, 4'd7, 7'd31, "R8 count7");
      step(1'b0, '0, '0, 1'b1, 4'd15, 7'd31, "R8 count15");
      probe(7'd31, 32'h31310000, "R8 nothing cancelled");

      // R5 / R10: rollback meeting retirement
      idle(DEPTH);
      step(1'b1, 7'd20, 32'h20202020, 1'b0, '0, 7'd20, "R10");
      idle(DEPTH - 1);
      step(1'b0, '0, '0, 1'b1, 4'(DEPTH), 7'd20, "R10 full");
      probe(7'd20, pat(20, 0), "R10 oldest discarded at p=DEPTH");
      step(1'b1, 7'd22, 32'h22222222, 1'b0, '0, 7'd22, "R10");
      idle(DEPTH - 1);
      step(1'b0, '0, '0, 1'b1, 4'(DEPTH - 1), 7'd22, "R10 partial");
      probe(7'd22, 32'h22222222, "R10 oldest retires at p<DEPTH");
      step(1'b1, 7'd21, 32'h21212121, 1'b0, '0, 7'd21, "R5");
      idle(DEPTH);
      step(1'b0, '0, '0, 1'b1, 4'(DEPTH), 7'd21, "R5");
      probe(7'd21, 32'h21212121, "R5 retired write survives");

      // mixed pattern across both ports with rollbacks interleaved
      for (int n = 0; n < 600; n++) begin
         step((n % 3) != 0, AW'((n * 37) & 7), pat(n, 1), (n % 11) == 10,
              CW'((n / 11) % 6), AW'((n * 5) & 7), "R6 mixed");
      end
      idle(DEPTH);
      for (int a = 0; a < WORDS; a++) probe(AW'(a), mread(AW'(a)), "R4 final sweep");

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule